// File: doc/BRIEF.md
# USB Receive Deserializer

This block sits behind the clock and data recovery of a USB receiver. It accepts one recovered line level per strobe and turns the stream into bytes on a parallel receive interface. A strobe can also mark a single-ended-zero bit. The block undoes the NRZI coding and hunts for the synchronization pattern. It then strips the stuffed zeros, collects eight data bits least significant first, and presents each finished byte for one clock. It also flags stuffing violations and closes the packet when a single-ended zero arrives.

Next to the data path, the block reports the bus line state from the single-ended DP and DM levels. In normal operation that report passes through a synchronizer to the word clock. While the link is in low-power mode, the report is taken straight from the pins, so that resume signalling is seen without a running clock.

Top module: `usb_rx_deser`

## Requirements
- R1: After reset, rx_active, rx_valid and rx_error are all 0.
- R2: Line level 1 is J and 0 is K. A strobed bit equal to the previous level decodes as 1, and a change of level decodes as 0. The reference level is J after reset and after every single-ended-zero strobe.
- R3: Outside a packet, a run of at least SYNC_MIN_ZEROS (default 5) decoded 0s followed by a decoded 1 starts a packet, and rx_active is 1 from the clock edge that samples that 1. A shorter run of 0s starts nothing.
- R4: Data bits are assembled least significant bit first. At the edge that samples the eighth data bit of a byte, rx_data takes the byte and rx_valid is 1 for exactly one cycle. rx_valid is only 1 while rx_active is 1.
- R5: After STUFF_RUN (default 6) consecutive decoded 1s, counting the final 1 of the synchronization pattern, a decoded 0 is dropped and does not enter the byte.
- R6: A decoded 1 in the slot where a stuffed 0 is due makes rx_error 1 for one cycle at the edge that samples it, and rx_active falls at that same edge. All further bits are ignored until the next single-ended-zero strobe, and no byte is delivered in that time.
- R7: A single-ended-zero strobe during a packet drops rx_active at the edge that samples it. Bits of an unfinished byte are discarded, and rx_error stays 0.
- R8: line_state bit 0 follows DP and bit 1 follows DM, giving 0 = SE0, 1 = J, 2 = K, 3 = SE1. With lowpower at 0, a pin change reaches line_state after SYNC_STAGES (default 2) clock edges.
- R9: With lowpower at 1, line_state equals {line_dm, line_dp} combinatorially, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe: bit_level and bit_se0 carry a new bit |
| bit_level | input | 1 | Recovered line level, 1 = J, 0 = K |
| bit_se0 | input | 1 | The strobed bit is a single-ended zero |
| line_dp | input | 1 | Single-ended DP receiver level |
| line_dm | input | 1 | Single-ended DM receiver level |
| lowpower | input | 1 | Suspended or resuming; selects the combinatorial line state |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | rx_data holds a new byte this cycle |
| rx_active | output | 1 | A packet is in progress |
| rx_error | output | 1 | Bit stuffing violation, aligned with the data timing |
| line_state | output | 2 | Line state {DM, DP} |

## Verification
The NRZI decode is combinatorial. As a result, rx_active, rx_valid, rx_data and rx_error all change at the single clock edge that samples the relevant strobe, with no further delay. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, which is half a period after that edge. line_state is due SYNC_STAGES edges after a pin change when lowpower is 0, so it is checked one edge too early and then on time. With lowpower at 1 it is checked a moment after the pin change, before any edge. Random gaps between strobes show that only strobed cycles advance the receiver.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    localparam logic IDLE_LEVEL = 1'b1;   // J

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_DATA  = 2'd1,
        ST_DRAIN = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic strobe;   // a bit is present this cycle
        logic eop;      // the bit is a single-ended zero
        logic val;      // decoded data value
    } dec_bit_t;

    // no transition -> 1, transition -> 0
    function automatic logic nrzi_decode(input logic prev_lvl, input logic cur_lvl);
        return ~(prev_lvl ^ cur_lvl);
    endfunction

endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi
    import usb_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_valid,
    input  logic     bit_level,
    input  logic     bit_se0,
    output dec_bit_t dout
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= IDLE_LEVEL;
        end else if (bit_valid) begin
            prev_q <= bit_se0 ? IDLE_LEVEL : bit_level;
        end
    end

    always_comb begin
        dout.strobe = bit_valid;
        dout.eop    = bit_se0;
        dout.val    = nrzi_decode(prev_q, bit_level);
    end

endmodule

// File: rtl/usb_rx_framer.sv
module usb_rx_framer
    import usb_rx_pkg::*;
#(
    parameter int SYNC_MIN_ZEROS = 5,
    parameter int STUFF_RUN      = 6,
    parameter int DATA_W         = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_bit_t          din,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_error,
    output logic              rx_active
);

    localparam int ZC_W = $clog2(SYNC_MIN_ZEROS + 1);
    localparam int OC_W = $clog2(STUFF_RUN + 1);
    localparam int BC_W = $clog2(DATA_W);
    localparam logic [ZC_W-1:0] ZC_MAX   = ZC_W'(SYNC_MIN_ZEROS);
    localparam logic [OC_W-1:0] OC_MAX   = OC_W'(STUFF_RUN);
    localparam logic [BC_W-1:0] BC_LAST  = BC_W'(DATA_W - 1);

    rx_state_e         state_q;
    logic [ZC_W-1:0]   zcnt_q;
    logic [OC_W-1:0]   ones_q;
    logic [BC_W-1:0]   bcnt_q;
    logic [DATA_W-2:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HUNT;
            zcnt_q   <= '0;
            ones_q   <= '0;
            bcnt_q   <= '0;
            shreg_q  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_error <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_error <= 1'b0;
            if (din.strobe) begin
                case (state_q)
                    ST_HUNT: begin
                        if (din.eop) begin
                            zcnt_q <= '0;
                        end else if (!din.val) begin
                            if (zcnt_q != ZC_MAX) zcnt_q <= zcnt_q + 1'b1;
                        end else begin
                            if (zcnt_q == ZC_MAX) begin
                                state_q <= ST_DATA;
                                ones_q  <= OC_W'(1);
                                bcnt_q  <= '0;
                            end
                            zcnt_q <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (din.eop) begin
                            state_q <= ST_HUNT;
                            zcnt_q  <= '0;
                        end else if (ones_q == OC_MAX) begin
                            if (din.val) begin
                                rx_error <= 1'b1;
                                state_q  <= ST_DRAIN;
                            end else begin
                                ones_q <= '0;
                            end
                        end else begin
                            ones_q <= din.val ? ones_q + 1'b1 : '0;
                            if (bcnt_q == BC_LAST) begin
                                rx_data  <= {din.val, shreg_q};
                                rx_valid <= 1'b1;
                                bcnt_q   <= '0;
                            end else begin
                                shreg_q <= {din.val, shreg_q[DATA_W-2:1]};
                                bcnt_q  <= bcnt_q + 1'b1;
                            end
                        end
                    end
                    ST_DRAIN: begin
                        if (din.eop) begin
                            state_q <= ST_HUNT;
                            zcnt_q  <= '0;
                        end
                    end
                    default: state_q <= ST_HUNT;
                endcase
            end
        end
    end

    assign rx_active = (state_q == ST_DATA);

endmodule

// File: rtl/usb_rx_linestate.sv
module usb_rx_linestate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_dp,
    input  logic       line_dm,
    input  logic       lowpower,
    output logic [1:0] line_state
);

    logic [1:0] stg_q [SYNC_STAGES];
    logic [1:0] raw;

    assign raw = {line_dm, line_dp};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= 2'b00;
        end else begin
            stg_q[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign line_state = lowpower ? raw : stg_q[SYNC_STAGES-1];

endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
    import usb_rx_pkg::*;
#(
    parameter int SYNC_MIN_ZEROS = 5,
    parameter int STUFF_RUN      = 6,
    parameter int DATA_W         = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_level,
    input  logic              bit_se0,
    input  logic              line_dp,
    input  logic              line_dm,
    input  logic              lowpower,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_active,
    output logic              rx_error,
    output logic [1:0]        line_state
);

    dec_bit_t dec;

    usb_rx_nrzi u_nrzi (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_level (bit_level),
        .bit_se0   (bit_se0),
        .dout      (dec)
    );

    usb_rx_framer #(
        .SYNC_MIN_ZEROS (SYNC_MIN_ZEROS),
        .STUFF_RUN      (STUFF_RUN),
        .DATA_W         (DATA_W)
    ) u_framer (
        .clk       (clk),
        .rst       (rst),
        .din       (dec),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_error  (rx_error),
        .rx_active (rx_active)
    );

    usb_rx_linestate #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ls (
        .clk        (clk),
        .rst        (rst),
        .line_dp    (line_dp),
        .line_dm    (line_dm),
        .lowpower   (lowpower),
        .line_state (line_state)
    );

endmodule

// File: rtl/usb_rx_deser_chk.sv
module usb_rx_deser_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_valid,
    input logic       bit_se0,
    input logic       line_dp,
    input logic       line_dm,
    input logic       lowpower,
    input logic       rx_valid,
    input logic       rx_active,
    input logic       rx_error,
    input logic [1:0] line_state
);

    a_r4_valid_single_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bit_valid));

    a_r4_valid_inside_packet: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_active);

    a_r3_start_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> ($past(bit_valid) && !$past(bit_se0)));

    a_r6_error_ends_packet: assert property (@(posedge clk) disable iff (rst)
        rx_error |-> !rx_active);

    a_r6_error_single_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_error |=> !rx_error);

    a_r7_eop_drops_active: assert property (@(posedge clk) disable iff (rst)
        (rx_active && bit_valid && bit_se0) |=> !rx_active);

    a_r9_lowpower_direct: assert property (@(posedge clk) disable iff (rst)
        lowpower |-> (line_state == {line_dm, line_dp}));

endmodule

bind usb_rx_deser usb_rx_deser_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_se0    (bit_se0),
    .line_dp    (line_dp),
    .line_dm    (line_dm),
    .lowpower   (lowpower),
    .rx_valid   (rx_valid),
    .rx_active  (rx_active),
    .rx_error   (rx_error),
    .line_state (line_state)
);

// File: tb/usb_rx_deser_tb.sv
module usb_rx_deser_tb;

    localparam int TX_SYNC_ZEROS = 7;
    localparam int STUFF_RUN     = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_valid = 1'b0;
    logic       bit_level = 1'b1;
    logic       bit_se0 = 1'b0;
    logic       line_dp = 1'b1;
    logic       line_dm = 1'b0;
    logic       lowpower = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_active;
    logic       rx_error;
    logic [1:0] line_state;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic lvl     = 1'b1;   // bench copy of the line level
    int  ones_tx  = 0;
    int  err_seen = 0;
    byte unsigned got_q[$];
    byte unsigned exp_q[$];

    always #2 clk = ~clk;

    usb_rx_deser u_dut (
        .clk (clk), .rst (rst), .bit_valid (bit_valid), .bit_level (bit_level),
        .bit_se0 (bit_se0), .line_dp (line_dp), .line_dm (line_dm),
        .lowpower (lowpower), .rx_data (rx_data), .rx_valid (rx_valid),
        .rx_active (rx_active), .rx_error (rx_error), .line_state (line_state)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) got_q.push_back(rx_data);
            if (rx_error) err_seen++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic level, input logic se0);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        @(negedge clk);
        bit_level = level;
        bit_se0   = se0;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_se0   = 1'b0;
    endtask

    // send one decoded bit through the bench NRZI encoder
    task automatic send_dec(input logic d);
        if (!d) lvl = ~lvl;
        drive_bit(lvl, 1'b0);
    endtask

    task automatic send_sync(input int zeros);
        for (int i = 0; i < zeros; i++) send_dec(1'b0);
        send_dec(1'b1);
        ones_tx = 1;
    endtask

    task automatic send_data_bit(input logic d);
        send_dec(d);
        ones_tx = d ? ones_tx + 1 : 0;
        if (ones_tx == STUFF_RUN) begin
            send_dec(1'b0);
            ones_tx = 0;
        end
    endtask

    task automatic send_byte(input byte unsigned b);
        for (int i = 0; i < 8; i++) send_data_bit(b[i]);
    endtask

    task automatic send_eop();
        drive_bit(1'b0, 1'b1);
        lvl = 1'b1;
        drive_bit(1'b1, 1'b0);
    endtask

    function automatic int bits_of(input byte unsigned b);
        return int'(b);
    endfunction

    task automatic compare_bytes(input string req);
        repeat (3) @(negedge clk);
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, bits_of(got_q[i]), bits_of(exp_q[i]));
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic run_packet(input byte unsigned pkt[$], input int extra, input string req);
        send_sync(TX_SYNC_ZEROS);
        foreach (pkt[i]) begin
            send_byte(pkt[i]);
            exp_q.push_back(pkt[i]);
        end
        for (int i = 0; i < extra; i++) send_data_bit(1'($urandom_range(0, 1)));
        send_eop();
        compare_bytes(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        byte unsigned pkt[$];
        int e0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(rx_active == 1'b0, "R1 rx_active", rx_active, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(rx_error == 1'b0, "R1 rx_error", rx_error, 0);

        // R2 R3 R4 directed packet, rx_active timing checked by hand
        send_sync(TX_SYNC_ZEROS);
        chk(rx_active == 1'b1, "R3 active after sync", rx_active, 1);
        send_byte(8'hA5); exp_q.push_back(8'hA5);
        send_byte(8'h3C); exp_q.push_back(8'h3C);
        drive_bit(1'b0, 1'b1);
        lvl = 1'b1;
        chk(rx_active == 1'b0, "R7 active drop at eop", rx_active, 0);
        drive_bit(1'b1, 1'b0);
        compare_bytes("R4 directed bytes");

        // R5 stuffing-heavy bytes
        pkt = '{8'hFF, 8'hFF, 8'h7F, 8'hFE};
        run_packet(pkt, 0, "R5 stuffed bytes");
        chk(err_seen == 0, "R5 no error", err_seen, 0);

        // R7 partial byte at EOP is dropped silently
        pkt = '{8'h12};
        run_packet(pkt, 5, "R7 partial byte");
        chk(err_seen == 0, "R7 no error", err_seen, 0);

        // R3 short sync run is ignored
        send_sync(3);
        chk(rx_active == 1'b0, "R3 short sync", rx_active, 0);
        for (int i = 0; i < 10; i++) send_dec(1'b1);
        repeat (3) @(negedge clk);
        chk(got_q.size() == 0, "R3 no bytes on short sync", got_q.size(), 0);

        // R6 stuffing violation
        e0 = err_seen;
        send_sync(TX_SYNC_ZEROS);
        send_byte(8'h00); exp_q.push_back(8'h00);
        for (int i = 0; i < 7; i++) send_dec(1'b1);
        chk(rx_error == 1'b1, "R6 error pulse", rx_error, 1);
        chk(rx_active == 1'b0, "R6 active cleared", rx_active, 0);
        for (int i = 0; i < 16; i++) send_dec(1'(i % 3 == 0));
        chk(rx_active == 1'b0, "R6 drain ignores bits", rx_active, 0);
        send_eop();
        compare_bytes("R6 bytes before error only");
        chk(err_seen == e0 + 1, "R6 one error", err_seen, e0 + 1);

        // R2 R4 random packets back to back
        for (int p = 0; p < 25; p++) begin
            pkt.delete();
            for (int i = 0; i < int'($urandom_range(1, 6)); i++)
                pkt.push_back(8'($urandom_range(0, 255)));
            run_packet(pkt, int'($urandom_range(0, 7)), "R4 random packet");
        end
        chk(err_seen == e0 + 1, "R2 no spurious error", err_seen, e0 + 1);

        // R8 synchronized line state
        @(negedge clk);
        line_dp = 1'b0; line_dm = 1'b1;
        #1 chk(line_state == 2'd1, "R8 no early change", line_state, 1);
        @(negedge clk);
        chk(line_state == 2'd1, "R8 one edge too early", line_state, 1);
        @(negedge clk);
        chk(line_state == 2'd2, "R8 K after two edges", line_state, 2);

        // R9 combinatorial path
        lowpower = 1'b1;
        line_dp = 1'b1; line_dm = 1'b1;
        #1 chk(line_state == 2'd3, "R9 SE1 direct", line_state, 3);
        line_dp = 1'b0; line_dm = 1'b0;
        #1 chk(line_state == 2'd0, "R9 SE0 direct", line_state, 0);
        line_dp = 1'b1;
        #1 chk(line_state == 2'd1, "R9 J direct", line_state, 1);
        @(negedge clk);
        lowpower = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule